// File: doc/BRIEF.md
# Time-Shared Cascaded Notch Filter

This block applies one second-order recursive notch section to each incoming sample many times in a row. The first pass filters the new sample, each later pass filters the output of the pass before it, and only the result of the last pass leaves the block. Running the same narrow notch several times in cascade deepens the rejection at the notch frequency. A typical use is removing mains hum from slowly sampled physiological signals, where a high-Q notch is wanted and the sample rate is far below the clock rate.

A single multiply-accumulate datapath serves every pass, one pass per clock. Each pass keeps its own four-word history, made of its previous two inputs and previous two outputs, in a small state memory indexed by pass number. The five coefficients and the pass count are written through simple write strobes. Any accepted configuration write zeroes the history of every pass.

Top module: `rnf_notch_refilter`

## Requirements
- R1: After reset, out_valid_o, busy_o and overrun_o are 0, the pass count is 1, b0 is 1.0 (16384) and b1, b2, a1, a2 are 0, so a sample comes out unchanged one cycle after acceptance.
- R2: Each pass computes y = sat(floor((b0*x + b1*x1 + b2*x2 - a1*y1 - a2*y2 + 8192) / 16384)), where x1, x2 are the pass's two previous inputs, y1, y2 its two previous outputs, coefficients are signed 16-bit with 14 fraction bits, and sat limits to the signed 16-bit range.
- R3: The output of pass k is the input of pass k+1; out_data_o carries only the final pass output, qualified by out_valid_o.
- R4: pass_data_i written with pass_wr_i sets the pass count; 0 means 1 pass, values above 128 mean 128 passes, and up to 128 passes are supported.
- R5: A sample accepted at a clock edge (in_valid_i high, busy_o low) yields out_valid_o exactly N clock edges later for N passes; busy_o is high from the edge after acceptance until that edge and low while out_valid_o is high.
- R6: Each pass index keeps its own history from one sample to the next.
- R7: in_valid_i while busy_o is high is dropped without effect on outputs or history and sets overrun_o, which stays 1 until reset.
- R8: A coefficient or pass-count write accepted while idle clears the history of every pass to zero.
- R9: Coefficient and pass-count writes made while busy_o is high are ignored and do not clear history.
- R10: Results beyond the 16-bit range are clamped to 32767 or -32768 at every pass.
- R11: coef_sel_i selects 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2; codes 5 to 7 write nothing and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | New input sample present |
| in_data_i | input | 16 | Signed input sample |
| coef_wr_i | input | 1 | Coefficient write strobe |
| coef_sel_i | input | 3 | Coefficient select code |
| coef_data_i | input | 16 | Signed Q2.14 coefficient value |
| pass_wr_i | input | 1 | Pass-count write strobe |
| pass_data_i | input | 8 | Requested pass count |
| out_valid_o | output | 1 | Final-pass result valid, one cycle |
| out_data_o | output | 16 | Signed final-pass result |
| busy_o | output | 1 | Passes in progress |
| overrun_o | output | 1 | Sticky dropped-sample flag |

## Verification
Random coefficient sets and random pass counts up to 100 are run over streams of random samples and compared against a bench model of the cascade with per-pass history, which tells apart errors in the arithmetic, in pass chaining and in history indexing. Directed cases isolate single effects: a half-gain b0 over two passes shows chaining, a pure one-sample delay over three passes shows that each pass keeps its own history, and full-scale inputs with near-2.0 gain show clamping in both directions. Writes during a busy period, samples arriving while busy, unused select codes and pass counts of 0, 100 and 200 separate the ignore, clear and clamp rules from the normal path.

// File: rtl/rnf_pkg.sv
package rnf_pkg;
    localparam int NUM_COEF = 5;

    typedef enum logic [2:0] {
        CSEL_B0 = 3'd0,
        CSEL_B1 = 3'd1,
        CSEL_B2 = 3'd2,
        CSEL_A1 = 3'd3,
        CSEL_A2 = 3'd4
    } coef_sel_e;
endpackage

// File: rtl/rnf_coef_bank.sv
module rnf_coef_bank
    import rnf_pkg::*;
#(
    parameter int COEF_W     = 16,
    parameter int FRAC       = 14,
    parameter int MAX_PASSES = 128,
    parameter int PASS_W     = $clog2(MAX_PASSES + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             busy_i,
    input  logic                             coef_wr_i,
    input  logic [2:0]                       coef_sel_i,
    input  logic [COEF_W-1:0]                coef_data_i,
    input  logic                             pass_wr_i,
    input  logic [PASS_W-1:0]                pass_data_i,
    output logic [NUM_COEF-1:0][COEF_W-1:0]  coef_o,
    output logic [PASS_W-1:0]                passes_o,
    output logic                             clear_o
);
    localparam logic [COEF_W-1:0] UNITY    = COEF_W'(1) << FRAC;
    localparam logic [PASS_W-1:0] PASS_MAX = PASS_W'(MAX_PASSES);

    typedef struct packed {
        logic [NUM_COEF-1:0][COEF_W-1:0] coef;
        logic [PASS_W-1:0]               passes;
        logic                            clr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.clr = 1'b0;
        if (!busy_i) begin
            if (coef_wr_i && coef_sel_i < 3'(NUM_COEF)) begin
                cfg_d.coef[coef_sel_i] = coef_data_i;
                cfg_d.clr              = 1'b1;
            end
            if (pass_wr_i) begin
                if (pass_data_i == '0)
                    cfg_d.passes = PASS_W'(1);
                else if (pass_data_i > PASS_MAX)
                    cfg_d.passes = PASS_MAX;
                else
                    cfg_d.passes = pass_data_i;
                cfg_d.clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q                     <= '0;
            cfg_q.coef[int'(CSEL_B0)] <= UNITY;
            cfg_q.passes              <= PASS_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign coef_o   = cfg_q.coef;
    assign passes_o = cfg_q.passes;
    assign clear_o  = cfg_q.clr;

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(cfg_q.coef) && $stable(cfg_q.passes) && !cfg_q.clr));

    p_pass_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.passes != '0) && (cfg_q.passes <= PASS_MAX));
endmodule

// File: rtl/rnf_hist_mem.sv
module rnf_hist_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     wr_en_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic signed [DATA_W-1:0] wr_x_i,
    input  logic signed [DATA_W-1:0] wr_y_i,
    output logic signed [DATA_W-1:0] x1_o,
    output logic signed [DATA_W-1:0] x2_o,
    output logic signed [DATA_W-1:0] y1_o,
    output logic signed [DATA_W-1:0] y2_o
);
    typedef struct packed {
        logic signed [DATA_W-1:0] x1;
        logic signed [DATA_W-1:0] x2;
        logic signed [DATA_W-1:0] y1;
        logic signed [DATA_W-1:0] y2;
    } ent_t;

    logic [DEPTH-1:0] live_d, live_q;
    ent_t             rd_arr [DEPTH];
    ent_t             cur_ent;
    ent_t             new_ent;

    assign cur_ent = live_q[idx_i] ? rd_arr[idx_i] : '0;

    always_comb begin
        new_ent.x1 = wr_x_i;
        new_ent.x2 = cur_ent.x1;
        new_ent.y1 = wr_y_i;
        new_ent.y2 = cur_ent.y1;
    end

    always_comb begin
        live_d = live_q;
        if (clear_i)
            live_d = '0;
        else if (wr_en_i)
            live_d[idx_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        ent_t ent_q;
        always_ff @(posedge clk) begin
            if (wr_en_i && !clear_i && idx_i == IDX_W'(i))
                ent_q <= new_ent;
        end
        assign rd_arr[i] = ent_q;
    end

    assign x1_o = cur_ent.x1;
    assign x2_o = cur_ent.x2;
    assign y1_o = cur_ent.y1;
    assign y2_o = cur_ent.y2;

    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (live_q == '0));

    p_write_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i) |=> live_q[$past(idx_i)]);
endmodule

// File: rtl/rnf_mac.sv
module rnf_mac
    import rnf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int FRAC   = 14
) (
    input  logic signed [DATA_W-1:0]         x_i,
    input  logic signed [DATA_W-1:0]         x1_i,
    input  logic signed [DATA_W-1:0]         x2_i,
    input  logic signed [DATA_W-1:0]         y1_i,
    input  logic signed [DATA_W-1:0]         y2_i,
    input  logic [NUM_COEF-1:0][COEF_W-1:0]  coef_i,
    output logic signed [DATA_W-1:0]         y_o
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [DATA_W-1:0] opnd [NUM_COEF];
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  shifted;

    assign opnd[0] = x_i;
    assign opnd[1] = x1_i;
    assign opnd[2] = x2_i;
    assign opnd[3] = y1_i;
    assign opnd[4] = y2_i;

    always_comb begin
        logic signed [PROD_W-1:0] prod;
        acc = RND;
        for (int k = 0; k < NUM_COEF; k++) begin
            prod = $signed(coef_i[k]) * opnd[k];
            if (k < 3) acc = acc + ACC_W'(prod);
            else       acc = acc - ACC_W'(prod);
        end
        shifted = acc >>> FRAC;
        if (shifted > MAXV)
            y_o = MAXV[DATA_W-1:0];
        else if (shifted < MINV)
            y_o = MINV[DATA_W-1:0];
        else
            y_o = shifted[DATA_W-1:0];
    end
endmodule

// File: rtl/rnf_notch_refilter.sv
module rnf_notch_refilter
    import rnf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int COEF_W     = 16,
    parameter int FRAC       = 14,
    parameter int MAX_PASSES = 128,
    parameter int PASS_W     = $clog2(MAX_PASSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              coef_wr_i,
    input  logic [2:0]        coef_sel_i,
    input  logic [COEF_W-1:0] coef_data_i,
    input  logic              pass_wr_i,
    input  logic [PASS_W-1:0] pass_data_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              busy_o,
    output logic              overrun_o
);
    localparam int IDX_W = $clog2(MAX_PASSES);

    typedef struct packed {
        logic                     busy;
        logic [IDX_W-1:0]         pass;
        logic signed [DATA_W-1:0] cur;
        logic                     out_valid;
        logic signed [DATA_W-1:0] out_data;
        logic                     overrun;
    } seq_t;

    seq_t st_d, st_q;

    logic [NUM_COEF-1:0][COEF_W-1:0] coef;
    logic [PASS_W-1:0]               passes;
    logic                            clear;
    logic [IDX_W-1:0]                last_idx;
    logic signed [DATA_W-1:0]        h_x1, h_x2, h_y1, h_y2;
    logic signed [DATA_W-1:0]        mac_y;

    rnf_coef_bank #(
        .COEF_W     (COEF_W),
        .FRAC       (FRAC),
        .MAX_PASSES (MAX_PASSES),
        .PASS_W     (PASS_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (st_q.busy),
        .coef_wr_i   (coef_wr_i),
        .coef_sel_i  (coef_sel_i),
        .coef_data_i (coef_data_i),
        .pass_wr_i   (pass_wr_i),
        .pass_data_i (pass_data_i),
        .coef_o      (coef),
        .passes_o    (passes),
        .clear_o     (clear)
    );

    rnf_hist_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_PASSES),
        .IDX_W  (IDX_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .wr_en_i (st_q.busy),
        .idx_i   (st_q.pass),
        .wr_x_i  (st_q.cur),
        .wr_y_i  (mac_y),
        .x1_o    (h_x1),
        .x2_o    (h_x2),
        .y1_o    (h_y1),
        .y2_o    (h_y2)
    );

    rnf_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC   (FRAC)
    ) u_mac (
        .x_i    (st_q.cur),
        .x1_i   (h_x1),
        .x2_i   (h_x2),
        .y1_i   (h_y1),
        .y2_i   (h_y2),
        .coef_i (coef),
        .y_o    (mac_y)
    );

    assign last_idx = IDX_W'(passes - PASS_W'(1));

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (st_q.busy) begin
            st_d.cur = mac_y;
            if (st_q.pass == last_idx) begin
                st_d.busy      = 1'b0;
                st_d.pass      = '0;
                st_d.out_valid = 1'b1;
                st_d.out_data  = mac_y;
            end else begin
                st_d.pass = st_q.pass + IDX_W'(1);
            end
            if (in_valid_i)
                st_d.overrun = 1'b1;
        end else if (in_valid_i) begin
            st_d.busy = 1'b1;
            st_d.pass = '0;
            st_d.cur  = $signed(in_data_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.out_valid;
    assign out_data_o  = st_q.out_data;
    assign busy_o      = st_q.busy;
    assign overrun_o   = st_q.overrun;

    p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !busy_o);

    p_busy_ends_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> out_valid_o);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    p_pass_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ({1'b0, st_q.pass} < (IDX_W + 1)'(passes)));

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && in_valid_i) |=>
            (busy_o && st_q.pass == '0 && st_q.cur == $signed($past(in_data_i))));
endmodule

// File: tb/rnf_notch_refilter_tb.sv
module rnf_notch_refilter_tb;
    localparam int DATA_W     = 16;
    localparam int COEF_W     = 16;
    localparam int FRAC       = 14;
    localparam int MAX_PASSES = 128;
    localparam int PASS_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              coef_wr = 1'b0;
    logic [2:0]        coef_sel = '0;
    logic [COEF_W-1:0] coef_data = '0;
    logic              pass_wr = 1'b0;
    logic [PASS_W-1:0] pass_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              busy;
    logic              overrun;

    always #5 clk = ~clk;

    rnf_notch_refilter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .coef_wr_i   (coef_wr),
        .coef_sel_i  (coef_sel),
        .coef_data_i (coef_data),
        .pass_wr_i   (pass_wr),
        .pass_data_i (pass_data),
        .out_valid_o (out_valid),
        .out_data_o  (out_data),
        .busy_o      (busy),
        .overrun_o   (overrun)
    );

    int checks = 0;
    int fails  = 0;
    int m_coef [5];
    int m_passes;
    int hx1 [MAX_PASSES];
    int hx2 [MAX_PASSES];
    int hy1 [MAX_PASSES];
    int hy2 [MAX_PASSES];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int eff_passes(input int v);
        if (v == 0) return 1;
        if (v > MAX_PASSES) return MAX_PASSES;
        return v;
    endfunction

    task automatic model_clear();
        for (int p = 0; p < MAX_PASSES; p++) begin
            hx1[p] = 0; hx2[p] = 0; hy1[p] = 0; hy2[p] = 0;
        end
    endtask

    task automatic model_sample(input int x, output int y);
        longint acc;
        int cur;
        int res;
        cur = x;
        for (int p = 0; p < m_passes; p++) begin
            acc = longint'(m_coef[0]) * cur + longint'(m_coef[1]) * hx1[p]
                + longint'(m_coef[2]) * hx2[p] - longint'(m_coef[3]) * hy1[p]
                - longint'(m_coef[4]) * hy2[p] + 8192;
            res = sat16(acc >>> 14);
            hx2[p] = hx1[p]; hx1[p] = cur;
            hy2[p] = hy1[p]; hy1[p] = res;
            cur = res;
        end
        y = cur;
    endtask

    task automatic write_coef(input int sel, input int val);
        @(negedge clk);
        coef_wr = 1'b1; coef_sel = 3'(sel); coef_data = COEF_W'(val);
        @(negedge clk);
        coef_wr = 1'b0;
    endtask

    task automatic write_passes(input int val);
        @(negedge clk);
        pass_wr = 1'b1; pass_data = PASS_W'(val);
        @(negedge clk);
        pass_wr = 1'b0;
    endtask

    task automatic set_coefs(input int b0, input int b1, input int b2, input int a1, input int a2);
        write_coef(0, b0); write_coef(1, b1); write_coef(2, b2);
        write_coef(3, a1); write_coef(4, a2);
        m_coef[0] = b0; m_coef[1] = b1; m_coef[2] = b2; m_coef[3] = a1; m_coef[4] = a2;
        model_clear();
    endtask

    task automatic set_passes(input int val);
        write_passes(val);
        m_passes = eff_passes(val);
        model_clear();
    endtask

    task automatic wait_out(output int lat);
        lat = 0;
        while (!out_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        if (!out_valid) check(1'b0, "watchdog", lat, m_passes);
    endtask

    task automatic run_sample(input int x, input string req);
        int exp_y;
        int lat;
        @(negedge clk);
        in_valid = 1'b1; in_data = DATA_W'(x);
        @(negedge clk);
        in_valid = 1'b0;
        check(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
        wait_out(lat);
        model_sample(x, exp_y);
        check(lat == m_passes, "R5 latency", lat, m_passes);
        check(busy == 1'b0, "R5 busy low at output", int'(busy), 0);
        check($signed(out_data) == exp_y, req, int'($signed(out_data)), exp_y);
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        int exp_y;
        void'($urandom(32'd20240611));
        m_coef[0] = 16384; m_coef[1] = 0; m_coef[2] = 0; m_coef[3] = 0; m_coef[4] = 0;
        m_passes = 1;
        model_clear();

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        run_sample(1234, "R1 pass-through default");
        run_sample(-777, "R1 pass-through negative");

        // R3 chaining: half gain, two passes
        set_coefs(8192, 0, 0, 0, 0);
        set_passes(2);
        run_sample(1000, "R3 chained half gain");
        check($signed(out_data) == 250, "R3 final value", int'($signed(out_data)), 250);

        // R6 per-pass history: pure delay over three passes
        set_coefs(0, 16384, 0, 0, 0);
        set_passes(3);
        run_sample(10, "R6 delay s0");
        run_sample(20, "R6 delay s1");
        run_sample(30, "R6 delay s2");
        run_sample(40, "R6 delay s3");
        check($signed(out_data) == 10, "R6 three-sample delay", int'($signed(out_data)), 10);

        // R8 idle write clears history
        write_coef(0, 0);
        model_clear();
        run_sample(50, "R8 after clear");
        check($signed(out_data) == 0, "R8 cleared history", int'($signed(out_data)), 0);

        // R11 unused select code writes nothing, clears nothing
        write_coef(6, 16384);
        run_sample(60, "R11 unused select");
        check($signed(out_data) == 0, "R11 no clear", int'($signed(out_data)), 0);
        run_sample(70, "R11 history kept");

        // R10 clamping both ways
        set_coefs(32767, 0, 0, 0, 0);
        set_passes(1);
        run_sample(30000, "R10 clamp high");
        check($signed(out_data) == 32767, "R10 high limit", int'($signed(out_data)), 32767);
        run_sample(-30000, "R10 clamp low");
        check($signed(out_data) == -32768, "R10 low limit", int'($signed(out_data)), -32768);

        // R4 pass count boundaries
        set_coefs(16384, 0, 0, 0, 0);
        set_passes(0);
        run_sample(321, "R4 zero means one");
        set_passes(200);
        run_sample(322, "R4 clamp to max");
        set_passes(100);
        run_sample(323, "R4 hundred passes");

        // R7 sample during busy dropped
        set_coefs(9000, 3000, 1000, -2000, 500);
        set_passes(5);
        @(negedge clk);
        in_valid = 1'b1; in_data = DATA_W'(4000);
        @(negedge clk);
        in_data = DATA_W'(-9999);
        @(negedge clk);
        in_valid = 1'b0;
        wait_out(lat);
        model_sample(4000, exp_y);
        check($signed(out_data) == exp_y, "R7 dropped sample no effect", int'($signed(out_data)), exp_y);
        check(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
        run_sample(1500, "R7 history untouched");
        check(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);

        // R9 writes while busy ignored
        set_passes(50);
        run_sample(2000, "R9 prime");
        @(negedge clk);
        in_valid = 1'b1; in_data = DATA_W'(2500);
        @(negedge clk);
        in_valid = 1'b0;
        coef_wr = 1'b1; coef_sel = 3'd0; coef_data = COEF_W'(100);
        pass_wr = 1'b1; pass_data = PASS_W'(7);
        @(negedge clk);
        coef_wr = 1'b0; pass_wr = 1'b0;
        wait_out(lat);
        model_sample(2500, exp_y);
        check(lat == 49, "R9 pass count unchanged", lat, 49);
        check($signed(out_data) == exp_y, "R9 coefs unchanged", int'($signed(out_data)), exp_y);
        run_sample(-2500, "R9 history not cleared");

        // R2 random coefficient sets, pass counts and samples
        for (int t = 0; t < 6; t++) begin
            int c [5];
            for (int k = 0; k < 5; k++) c[k] = int'($urandom_range(0, 32767)) - 16384;
            set_coefs(c[0], c[1], c[2], c[3], c[4]);
            set_passes(int'($urandom_range(1, 100)));
            for (int s = 0; s < 8; s++)
                run_sample(int'($urandom_range(0, 65535)) - 32768, "R2 random cascade");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule